// File: doc/BRIEF.md
# Eight-Pin Bidirectional Port with Direction and Digital-Input Control

This block is a general-purpose I/O port of eight pins that software configures through a small register bus. The bus has an address, write data, a write strobe and a combinational read-data return. Three registers live behind it. The direction register selects, pin by pin, whether the port drives the pin. The output latch holds the value driven on pins set as outputs. The input-enable mask decides whether a pin set as an input is sampled as a digital level or left to an analog converter elsewhere on the chip.

On the pin side the block presents three buses: output values, output enables, and input levels from the pads. Input levels cross into the clock domain through a two-stage synchronizer before they reach the read multiplexer. A read of the data register mixes three sources bit by bit:
- a pin set as an output returns its latch bit;
- a pin set as an enabled input returns its synchronized level;
- a pin set as an input whose enable bit is clear returns zero.

The pads and the converter are not part of the block.

Top module: `pin_bank_port`

## Requirements
- R1: After reset the direction, input-enable and output-latch registers all hold zero. Every output enable is low, every output value is low, and every register read returns 0x00 whatever the pin levels are.
- R2: Writing the direction register at offset 2 sets output enable bit n equal to bit n of the written value (1 = output, 0 = input) from the next clock edge. A read of offset 2 returns the stored value.
- R3: Writing the data register at offset 0 loads the output latch, which drives the output values. The latch keeps its value until the next write to offset 0; writes to other offsets leave it unchanged.
- R4: On a read of offset 0, every bit whose direction bit is 1 returns the latch bit, not the pin level.
- R5: On a read of offset 0, every bit whose direction bit is 0 and whose input-enable bit is 1 returns the pin level. A change at the pin appears in read data after exactly two rising clock edges.
- R6: On a read of offset 0, every bit whose direction bit is 0 and whose input-enable bit is 0 returns 0.
- R7: The input-enable mask sits at offset 4 and reads back as written. Reads of any other offset (1, 3, 5 to 15) return 0x00, and writes to them change no register.
- R8: With the write strobe low, no register changes, whatever the address and write data.
- R9: Writing 0xF0 to the direction register makes pins 7 to 4 outputs and pins 3 to 0 inputs.
- R10: A read issued in the same cycle as a write to the same register returns the old contents. The new contents are visible from the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 4 | Register offset |
| regWdata | input | 8 | Write data |
| regWe | input | 1 | Write strobe |
| regRdata | output | 8 | Read data, combinational from the address |
| pinOut | output | 8 | Output values toward the pads |
| pinOe | output | 8 | Output enables, 1 drives the pin |
| pinIn | input | 8 | Pin levels from the pads |

## Verification
Two functions can coincide in one cycle: a register write and a read of the same register, or a direction change and a data read that depends on it. The bench provokes this by driving the write strobe while the address already selects the register under test. It then checks that read data in that cycle still shows the old contents and switches on the next cycle. A second overlap arises when a pin level changes while the data register is being read. The bench checks that the old level is still returned one edge after the change and the new level after two. A sweep over all 256 direction patterns checks the bitwise mix of latch, pin level and zero against an arithmetic model.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_IEN  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrData;
    logic   wrDir;
    logic   wrIen;
    rdSel_e rdSel;
  } ctlStrobe_t;

endpackage

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl
  import pin_bank_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_OFS = 0,
  parameter int unsigned DIR_OFS  = 2,
  parameter int unsigned IEN_OFS  = 4
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  output ctlStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] DataA = ADDR_W'(DATA_OFS);
  localparam logic [ADDR_W-1:0] DirA  = ADDR_W'(DIR_OFS);
  localparam logic [ADDR_W-1:0] IenA  = ADDR_W'(IEN_OFS);

  logic hitData;
  logic hitDir;
  logic hitIen;

  assign hitData = (regAddr == DataA);
  assign hitDir  = (regAddr == DirA);
  assign hitIen  = (regAddr == IenA);

  always_comb begin
    strobe.wrData = regWe & hitData;
    strobe.wrDir  = regWe & hitDir;
    strobe.wrIen  = regWe & hitIen;
    if (hitData)      strobe.rdSel = SEL_DATA;
    else if (hitDir)  strobe.rdSel = SEL_DIR;
    else if (hitIen)  strobe.rdSel = SEL_IEN;
    else              strobe.rdSel = SEL_NONE;
  end

endmodule

// File: rtl/pin_bank_datapath.sv
module pin_bank_datapath
  import pin_bank_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [WIDTH-1:0] regWdata,
  output logic [WIDTH-1:0] regRdata,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe,
  input  logic [WIDTH-1:0] pinIn
);

  localparam int unsigned LastStage = SYNC_STAGES - 1;

  logic [WIDTH-1:0] dirQ;
  logic [WIDTH-1:0] ienQ;
  logic [WIDTH-1:0] latchQ;
  logic [WIDTH-1:0] syncQ [SYNC_STAGES];
  logic [WIDTH-1:0] dataView;

  // configuration and output registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ   <= '0;
      ienQ   <= '0;
      latchQ <= '0;
    end else begin
      if (strobe.wrDir)  dirQ   <= regWdata;
      if (strobe.wrIen)  ienQ   <= regWdata;
      if (strobe.wrData) latchQ <= regWdata;
    end
  end

  // input synchronizer chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= '0;
    else       syncQ[0] <= pinIn;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[s] <= '0;
      else       syncQ[s] <= syncQ[s-1];
    end
  end

  // per-pin view of the data register
  for (genvar b = 0; b < WIDTH; b++) begin : gView
    assign dataView[b] = dirQ[b] ? latchQ[b] : (ienQ[b] & syncQ[LastStage][b]);
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_DATA: regRdata = dataView;
      SEL_DIR:  regRdata = dirQ;
      SEL_IEN:  regRdata = ienQ;
      default:  regRdata = '0;
    endcase
  end

  assign pinOut = latchQ;
  assign pinOe  = dirQ;

endmodule

// File: rtl/pin_bank_port.sv
module pin_bank_port
  import pin_bank_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DATA_OFS    = 0,
  parameter int unsigned DIR_OFS     = 2,
  parameter int unsigned IEN_OFS     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WIDTH-1:0]  regWdata,
  input  logic              regWe,
  output logic [WIDTH-1:0]  regRdata,
  output logic [WIDTH-1:0]  pinOut,
  output logic [WIDTH-1:0]  pinOe,
  input  logic [WIDTH-1:0]  pinIn
);

  ctlStrobe_t strobe;

  pin_bank_ctrl #(
    .ADDR_W   (ADDR_W),
    .DATA_OFS (DATA_OFS),
    .DIR_OFS  (DIR_OFS),
    .IEN_OFS  (IEN_OFS)
  ) uCtrl (
    .regAddr (regAddr),
    .regWe   (regWe),
    .strobe  (strobe)
  );

  pin_bank_datapath #(
    .WIDTH       (WIDTH),
    .SYNC_STAGES (SYNC_STAGES)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .pinIn    (pinIn)
  );

endmodule

// File: rtl/pin_bank_chk.sv
module pin_bank_chk #(
  parameter int unsigned WIDTH    = 8,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_OFS = 0,
  parameter int unsigned DIR_OFS  = 2,
  parameter int unsigned IEN_OFS  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic [WIDTH-1:0]  regWdata,
  input logic              regWe,
  input logic [WIDTH-1:0]  regRdata,
  input logic [WIDTH-1:0]  pinOut,
  input logic [WIDTH-1:0]  pinOe
);

  localparam logic [ADDR_W-1:0] DataA = ADDR_W'(DATA_OFS);
  localparam logic [ADDR_W-1:0] DirA  = ADDR_W'(DIR_OFS);
  localparam logic [ADDR_W-1:0] IenA  = ADDR_W'(IEN_OFS);

  logic [WIDTH-1:0] ienModel;
  logic [WIDTH-1:0] latchModel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ienModel   <= '0;
      latchModel <= '0;
    end else if (regWe) begin
      if (regAddr == IenA)  ienModel   <= regWdata;
      if (regAddr == DataA) latchModel <= regWdata;
    end
  end

  a_r2_oe_follows_dir_write: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == DirA) |=> (pinOe == $past(regWdata)));

  a_r3_out_matches_last_write: assert property (@(posedge clk) disable iff (!rstN)
    pinOut == latchModel);

  a_r3_latch_holds: assert property (@(posedge clk) disable iff (!rstN)
    !(regWe && regAddr == DataA) |=> $stable(pinOut));

  a_r4_output_bits_read_latch: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == DataA) |-> ((regRdata & pinOe) == (pinOut & pinOe)));

  a_r6_disabled_inputs_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == DataA) |-> ((regRdata & ~pinOe & ~ienModel) == '0));

  a_r7_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr != DataA && regAddr != DirA && regAddr != IenA) |-> (regRdata == '0));

  a_r8_no_strobe_no_change: assert property (@(posedge clk) disable iff (!rstN)
    !regWe |=> ($stable(pinOe) && $stable(pinOut)));

endmodule

bind pin_bank_port pin_bank_chk #(
  .WIDTH    (WIDTH),
  .ADDR_W   (ADDR_W),
  .DATA_OFS (DATA_OFS),
  .DIR_OFS  (DIR_OFS),
  .IEN_OFS  (IEN_OFS)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .regAddr  (regAddr),
  .regWdata (regWdata),
  .regWe    (regWe),
  .regRdata (regRdata),
  .pinOut   (pinOut),
  .pinOe    (pinOe)
);

// File: tb/sim_pin_bank_port.sv
`timescale 1ns/1ps
module sim_pin_bank_port;

  localparam logic [3:0] A_DATA = 4'd0;
  localparam logic [3:0] A_DIR  = 4'd2;
  localparam logic [3:0] A_IEN  = 4'd4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic       regWe = 1'b0;
  logic [7:0] regRdata;
  logic [7:0] pinOut;
  logic [7:0] pinOe;
  logic [7:0] pinIn = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pin_bank_port u0 (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regWe    (regWe),
    .regRdata (regRdata),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .pinIn    (pinIn)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] v);
    @(negedge clk);
    regAddr = a; regWdata = v; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    regAddr = a; regWe = 1'b0;
    #1 v = regRdata;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    pinIn = 8'hFF;
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 oe", pinOe, 8'h00);
    chk("R1 out", pinOut, 8'h00);
    rd(A_DIR, v);  chk("R1 dir", v, 8'h00);
    rd(A_IEN, v);  chk("R1 ien", v, 8'h00);
    rd(A_DATA, v); chk("R1 data", v, 8'h00);

    // R9 direction split
    wr(A_DIR, 8'hF0);
    #1 chk("R9 oe", pinOe, 8'hF0);
    rd(A_DIR, v); chk("R2 dir readback", v, 8'hF0);

    // R3 latch and hold
    wr(A_DATA, 8'hA5);
    #1 chk("R3 out", pinOut, 8'hA5);
    wr(A_DIR, 8'h0F);
    wr(A_IEN, 8'h33);
    #1 chk("R3 hold", pinOut, 8'hA5);
    rd(A_IEN, v); chk("R7 ien readback", v, 8'h33);

    // R7 unmapped offsets
    for (int a = 0; a < 16; a++) begin
      if (a != 0 && a != 2 && a != 4) begin
        wr(4'(a), 8'h5C);
        rd(4'(a), v); chk("R7 unmapped read", v, 8'h00);
      end
    end
    chk("R7 oe unchanged", pinOe, 8'h0F);
    chk("R7 out unchanged", pinOut, 8'hA5);
    rd(A_IEN, v); chk("R7 ien unchanged", v, 8'h33);

    // R8 no strobe
    for (int a = 0; a < 6; a++) begin
      @(negedge clk);
      regAddr = 4'(a); regWdata = 8'hC3; regWe = 1'b0;
    end
    @(negedge clk);
    chk("R8 oe", pinOe, 8'h0F);
    chk("R8 out", pinOut, 8'hA5);
    rd(A_IEN, v); chk("R8 ien", v, 8'h33);

    // R5 latency: all inputs enabled
    wr(A_DIR, 8'h00);
    wr(A_IEN, 8'hFF);
    @(negedge clk); regAddr = A_DATA; pinIn = 8'h00;
    repeat (3) @(negedge clk);
    #1 chk("R5 settle", regRdata, 8'h00);
    pinIn = 8'h96;
    @(negedge clk); #1 chk("R5 one edge old", regRdata, 8'h00);
    @(negedge clk); #1 chk("R5 two edges new", regRdata, 8'h96);

    // R10 read in the write cycle
    @(negedge clk);
    regAddr = A_DIR; regWdata = 8'h3C; regWe = 1'b1;
    #1 chk("R10 old dir", regRdata, 8'h00);
    @(negedge clk); regWe = 1'b0;
    #1 chk("R10 new dir", regRdata, 8'h3C);

    // R4 R5 R6 sweep over all direction patterns
    for (int d = 0; d < 256; d++) begin
      logic [7:0] dir, ien, lat, pin, exp;
      dir = 8'(d);
      ien = dir ^ 8'h5A;
      lat = ~dir ^ 8'(d * 3);
      pin = 8'(d * 37 + 11);
      wr(A_DIR, dir);
      wr(A_IEN, ien);
      wr(A_DATA, lat);
      pinIn = pin;
      @(negedge clk);
      rd(A_DATA, v);
      exp = (dir & lat) | (~dir & ien & pin);
      chk("R4 R5 R6 data mix", v, exp);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule